// File: doc/BRIEF.md
# Bit-Serial Carry-Save Multiplier

The block multiplies two unsigned WIDTH-bit numbers. One operand, the multiplicand, is presented in parallel and captured when an operation starts. The other, the multiplier, arrives one bit at a time, least significant bit first, each bit qualified by a valid strobe. The product leaves the block one bit per step, least significant bit first, 2*WIDTH bits in all.

Inside are WIDTH full-adder cells. In each step, every cell adds three values: the AND of its multiplicand bit with the current multiplier bit, the registered sum of the cell one position higher, and its own registered carry. Every carry stays in a flip-flop beside its adder instead of rippling. Each step therefore costs one full-adder delay at any width. The lowest cell's registered sum is the product bit for that step. Once the last multiplier bit is taken, the block runs WIDTH more steps on its own with a zero multiplier bit. These steps drain the stored sums and carries.

A user pulses `start_i` with the multiplicand on `a_i`. The user then supplies WIDTH valid multiplier bits, gaps allowed, and collects every bit flagged by `p_valid_o`. `done_o` marks the final bit.

Top module: `csm_serial_mult`

## Requirements
- R1: After reset is released and before any start, `p_valid_o` and `done_o` are 0.
- R2: The 2*WIDTH bits flagged by `p_valid_o` for one operation, taken in order as bit 0 upward, equal the unsigned product of the captured multiplicand and the WIDTH multiplier bits. Multiplier bit k is the k-th valid bit and has weight 2^k.
- R3: Each operation flags exactly 2*WIDTH product bits. `done_o` is 1 together with the last of them, and at no other time.
- R4: While the block waits for multiplier bits, a cycle with `b_valid_i` low does no step: `p_valid_o` is 0 in the following cycle, and the product is unchanged by the gap.
- R5: A valid multiplier bit accepted at a clock edge produces its product bit with `p_valid_o` high in the cycle after that edge.
- R6: `start_i` clears all stored sums and carries and restarts the operation, even in the middle of an operation. No step is done in the start cycle.
- R7: When no operation is active, `b_valid_i` and `b_i` have no effect: `p_valid_o` and `done_o` stay 0.
- R8: The multiplicand is sampled from `a_i` only in the `start_i` cycle. Later changes of `a_i` do not change the product.
- R9: After the WIDTH-th multiplier bit, the block steps in each of the next WIDTH cycles whatever `b_valid_i` and `b_i` do, so `p_valid_o` is high for WIDTH consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures `a_i` and clears the datapath |
| a_i | input | WIDTH | Parallel multiplicand |
| b_i | input | 1 | Serial multiplier bit, LSB first |
| b_valid_i | input | 1 | Qualifies `b_i` |
| p_o | output | 1 | Serial product bit, LSB first |
| p_valid_o | output | 1 | Qualifies `p_o` |
| done_o | output | 1 | High with the final product bit |

## Verification
The assertions assume that `start_i` is a single-cycle pulse given while the clock runs. They also assume that, after a start, multiplier bits come only through `b_valid_i`, so that idle and gap cycles show up as missing steps. The stimulus holds `start_i` for exactly one cycle. It inserts random gaps only while multiplier bits are still owed. During the drain steps and when idle, it drives random junk on `b_i` and `b_valid_i`, where those pins are specified to have no effect. An abort case issues a new start part-way through an operation, which checks that the clear on start keeps the stored state from leaking into the next product.

// File: rtl/csm_pkg.sv
`timescale 1ns/1ps
package csm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOAD  = 2'd1,
    PH_FLUSH = 2'd2
  } csm_phase_e;
endpackage

// File: rtl/csm_fa_cell.sv
`timescale 1ns/1ps
module csm_fa_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  logic a_bit_i,
  input  logic b_bit_i,
  input  logic sum_in_i,
  output logic sum_o,
  output logic carry_o
);
  logic sum_q, carry_q;
  logic pp;
  logic [1:0] fa_res;

  assign pp     = a_bit_i & b_bit_i;
  assign fa_res = {1'b0, pp} + {1'b0, sum_in_i} + {1'b0, carry_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q   <= 1'b0;
      carry_q <= 1'b0;
    end else if (clr_i) begin
      sum_q   <= 1'b0;
      carry_q <= 1'b0;
    end else if (step_i) begin
      sum_q   <= fa_res[0];
      carry_q <= fa_res[1];
    end
  end

  assign sum_o   = sum_q;
  assign carry_o = carry_q;

  // gap or idle cycles leave stored state untouched
  assert_hold_no_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> ($stable(sum_q) && $stable(carry_q)));
endmodule

// File: rtl/csm_ctrl.sv
`timescale 1ns/1ps
module csm_ctrl
  import csm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       b_i,
  input  logic       b_valid_i,
  output logic       step_o,
  output logic       mult_bit_o,
  output logic       last_o,
  output csm_phase_e phase_o
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

  csm_phase_e phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      phase_q <= PH_LOAD;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_LOAD: if (b_valid_i) begin
          if (cnt_q == LAST_CNT) begin
            phase_q <= PH_FLUSH;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_FLUSH: begin
          if (cnt_q == LAST_CNT) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  assign step_o     = !start_i && ((phase_q == PH_LOAD && b_valid_i) || phase_q == PH_FLUSH);
  assign mult_bit_o = (phase_q == PH_LOAD) && b_i;
  assign last_o     = (phase_q == PH_FLUSH) && (cnt_q == LAST_CNT);
  assign phase_o    = phase_q;

  // drain runs to completion once entered
  assert_flush_continues_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FLUSH && cnt_q != LAST_CNT && !start_i) |=> (phase_q == PH_FLUSH));
endmodule

// File: rtl/csm_serial_mult.sv
`timescale 1ns/1ps
module csm_serial_mult
  import csm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic             b_i,
  input  logic             b_valid_i,
  output logic             p_o,
  output logic             p_valid_o,
  output logic             done_o
);
  logic [WIDTH-1:0] a_q;
  logic [WIDTH-1:0] sum_vec, carry_vec;
  logic step, mult_bit, last;
  logic p_valid_q, done_q;
  csm_phase_e phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) a_q <= '0;
    else if (start_i) a_q <= a_i;
  end

  csm_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .b_i        (b_i),
    .b_valid_i  (b_valid_i),
    .step_o     (step),
    .mult_bit_o (mult_bit),
    .last_o     (last),
    .phase_o    (phase)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic sum_in;
    if (i == WIDTH - 1) begin : g_top
      assign sum_in = 1'b0;
    end else begin : g_mid
      assign sum_in = sum_vec[i+1];
    end
    csm_fa_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (start_i),
      .step_i   (step),
      .a_bit_i  (a_q[i]),
      .b_bit_i  (mult_bit),
      .sum_in_i (sum_in),
      .sum_o    (sum_vec[i]),
      .carry_o  (carry_vec[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_valid_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      p_valid_q <= step;
      done_q    <= step && last;
    end
  end

  assign p_o       = sum_vec[0];
  assign p_valid_o = p_valid_q;
  assign done_o    = done_q;

  assert_done_with_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> p_valid_o);

  // after the final step only the output bit may remain
  assert_drained_at_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (carry_vec == '0 && (sum_vec >> 1) == '0));

  assert_idle_ignores_input_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_IDLE && !start_i) |=> (!p_valid_o && !done_o));

  assert_gap_no_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_LOAD && !b_valid_i && !start_i) |=> !p_valid_o);

  assert_start_no_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!p_valid_o && !done_o));
endmodule

// File: tb/csm_serial_mult_tb.sv
`timescale 1ns/1ps
module csm_serial_mult_tb_top;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] a_in = '0;
  logic b_in = 1'b0;
  logic b_valid = 1'b0;
  logic p_out, p_valid, done;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  csm_serial_mult #(.WIDTH(N)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .a_i       (a_in),
    .b_i       (b_in),
    .b_valid_i (b_valid),
    .p_o       (p_out),
    .p_valid_o (p_valid),
    .done_o    (done)
  );

  function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    return {{N{1'b0}}, a} * {{N{1'b0}}, b};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one operation; gap_pct = chance of an idle slot while bits are owed
  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b,
                        input int gap_pct, input bit scramble_a);
    logic [2*N-1:0] got = '0;
    int nbits = 0, ndone = 0, k = 0, fl = N, guard = 0;
    bit exp_step = 1'b0, done_ok = 1'b1, step_ok = 1'b1, fin = 1'b0;
    @(negedge clk);
    start = 1'b1; a_in = a; b_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (scramble_a) a_in = ~a; // R8
    while (!fin && guard < 20 * N) begin
      guard++;
      // sample result of the previous edge
      if (p_valid !== exp_step) step_ok = 1'b0;
      if (p_valid === 1'b1) begin
        if (nbits < 2 * N) got[nbits] = p_out;
        nbits++;
      end
      if (done === 1'b1) begin
        ndone++;
        if (nbits != 2 * N) done_ok = 1'b0;
      end
      if (k == N && fl == 0) begin
        fin = 1'b1;
      end else if (k < N) begin
        if (int'($urandom_range(99)) < gap_pct) begin
          b_valid = 1'b0; b_in = 1'($urandom); exp_step = 1'b0;
        end else begin
          b_valid = 1'b1; b_in = b[k]; k++; exp_step = 1'b1;
        end
      end else begin
        b_valid = 1'($urandom); b_in = 1'($urandom); // R9 junk during drain
        exp_step = 1'b1; fl--;
      end
      if (!fin) @(negedge clk);
    end
    b_valid = 1'b0;
    chk(got == ref_mul(a, b), "R2", "product", longint'(got), longint'(ref_mul(a, b)));
    chk(nbits == 2 * N, "R3", "bit count", nbits, 2 * N);
    chk(ndone == 1 && done_ok, "R3", "done placement", ndone, 1);
    chk(step_ok, "R5", "valid timing (R4 gaps, R9 drain)", 0, 1);
  endtask

  initial begin
    #1200000;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    repeat (2) begin
      @(negedge clk);
      chk(p_valid === 1'b0 && done === 1'b0, "R1", "idle after reset", {p_valid, done}, 0);
    end

    // R2 directed corners
    run_op('0, '0, 0, 1'b0);
    run_op('1, '1, 0, 1'b0);
    run_op(N'(1), '1, 0, 1'b0);
    run_op('1, N'(1), 0, 1'b0);
    run_op('0, '1, 0, 1'b0);
    run_op(N'(1), N'(1), 0, 1'b0);

    // R4 gaps in the multiplier stream
    run_op('1, '1, 60, 1'b0);
    run_op(N'(8'hA5), N'(8'h5A), 50, 1'b0);

    // R8 multiplicand changes after start
    run_op(N'(8'hC3), N'(8'h7E), 20, 1'b1);

    // R7 idle junk ignored
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(p_valid === 1'b0 && done === 1'b0, "R7", "idle output", {p_valid, done}, 0);
      b_valid = 1'b1; b_in = 1'($urandom);
    end
    @(negedge clk);
    chk(p_valid === 1'b0 && done === 1'b0, "R7", "idle output", {p_valid, done}, 0);
    b_valid = 1'b0;

    // R6 abort mid-operation, then a clean one
    @(negedge clk);
    start = 1'b1; a_in = '1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < N / 2 + 1; i++) begin
      b_valid = 1'b1; b_in = 1'b1;
      @(negedge clk);
    end
    b_valid = 1'b0;
    run_op(N'(8'h13), N'(8'h9B), 0, 1'b0); // R6 restart
    // abort during drain
    @(negedge clk);
    start = 1'b1; a_in = '1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < N + 2; i++) begin
      b_valid = 1'b1; b_in = 1'b1;
      @(negedge clk);
    end
    b_valid = 1'b0;
    run_op(N'(8'h02), N'(8'h81), 0, 1'b0); // R6 restart

    // random mix
    for (int i = 0; i < 40; i++) begin
      run_op(N'($urandom), N'($urandom), int'($urandom_range(40)), 1'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule